// File: doc/BRIEF.md
# Prioritized Locality Ownership Arbiter

This block decides which of five software localities (numbered 0 to 4) currently owns a security module. Each locality writes strobes into its own control register to ask for the module, hand it back, force a takeover, or raise the established flag. It reads its own status register to learn whether it holds the module and whether it was pushed off. A shared state register shows whether any locality holds the module, which one it is, and the established flag.

Register access uses one narrow port. A write strobe, a 2-bit register selector and a 3-bit locality tag arrive with the write data. Reads are combinational from the registered state, addressed by the same selector and tag. A write changes the state at the next rising edge, and the new state can be read during the following cycle. Pending requests are resolved in the same update. When nobody owns the module, the highest-numbered pending locality wins. A higher locality can pre-empt a lower owner outright, and the loser keeps a sticky flag that records it. A separate single-cycle event input clears the established flag.

Top module: `loc_arb_top`

## Requirements
- R1: After reset the state register reads 0x80, and the status register of every locality reads 0x00.
- R2: Selector 0 reads the state register: bit 7 always 1, bits [4:2] the owner number (0 when no locality holds the module), bit 1 assigned, bit 0 established. Selector 1 (control) reads 0. Selector 2 reads the status register of the tagged locality.
- R3: A control write with bit 0 set (request) from a non-owner marks that locality pending. If no locality holds the module after the write, the highest-numbered pending locality is granted in that same update, and its pending mark is cleared.
- R4: A control write with bit 1 set (relinquish) from the owner frees the module. The highest pending locality is granted in that same update, or the state goes unassigned if none is pending.
- R5: A relinquish from a locality that does not own the module only drops that locality's pending mark. The owner is unchanged.
- R6: A request from the current owner changes nothing.
- R7: A control write with bit 2 set (seize) moves ownership to the writer only when a locality holds the module and the writer's number is higher than the owner's. The previous owner's status bit 1 (been seized) is then set. A seize from an equal or lower locality, or with no owner, is ignored. Within one write, seize takes precedence over relinquish, and relinquish over request.
- R8: The been-seized flag of a locality stays set until that locality writes a request or a relinquish.
- R9: Status bit 0 (granted) reads 1 exactly when the tagged locality is the owner.
- R10: A control write with bit 3 set sets the established flag only when it comes from locality 3 or 4. A pulse on hash_end clears the flag, and it wins over a set in the same cycle.
- R11: Writes tagged with a locality number of 5 or more, and writes to selectors 0, 2 or 3, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register selector: 0 state, 1 control, 2 status |
| reg_loc | input | 3 | Locality tag of the access |
| reg_wdata | input | 8 | Write data |
| hash_end | input | 1 | Single-cycle event that clears the established flag |
| reg_rdata | output | 8 | Combinational read data |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- A relinquish while several localities are pending. A wrong scan order hands the module to the lowest pending locality, and a missing clear leaves the winner pending after it becomes owner.
- A relinquish from a locality that is not the owner. A design that skips the owner comparison frees the module.
- A seize from a lower locality, from the owner itself, and with the module free. A design that drops the priority comparison steals ownership, or sets a been-seized flag that should stay clear.
- A write carrying several strobes at once. A design with the wrong precedence grants through the request bit after a failed seize.
- A hash_end pulse in the same cycle as an establishment write, and an establishment write from locality 2. Wrong priority, or a missing privilege check, leaves the flag set.
- A long random stream compared cycle by cycle against a behavioural model. It catches drift in the sticky flags after many hand-offs.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

   // width of the owner field in the state register
   localparam int LOC_W = 3;

   // register selectors on the access port
   typedef enum logic [1:0] {
      SEL_STATE = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // control register strobe positions
   localparam int CB_REQ   = 0;
   localparam int CB_REL   = 1;
   localparam int CB_SEIZE = 2;
   localparam int CB_EST   = 3;

   // state register layout
   localparam int ST_EST      = 0;
   localparam int ST_ASSIGNED = 1;
   localparam int ST_LOC_LSB  = 2;
   localparam int ST_VALID    = 7;

   // status register layout
   localparam int SS_GRANT  = 0;
   localparam int SS_SEIZED = 1;

   // one decoded action per control write
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_REQ   = 2'd1,
      ACT_REL   = 2'd2,
      ACT_SEIZE = 2'd3
   } loc_act_e;

endpackage

// File: rtl/loc_ctrl_decode.sv
module loc_ctrl_decode
   import loc_arb_pkg::*;
#(
   parameter int NUM_LOC     = 5,
   parameter int DATA_W      = 8,
   parameter int EST_MIN_LOC = 3
) (
   input  logic              wr,
   input  logic [1:0]        sel,
   input  logic [LOC_W-1:0]  loc,
   input  logic [DATA_W-1:0] wdata,
   output loc_act_e          act,
   output logic [LOC_W-1:0]  act_loc,
   output logic              est_set
);

   logic loc_ok;
   logic ctrl_hit;

   assign loc_ok   = ({1'b0, loc} < (LOC_W+1)'(NUM_LOC));
   assign ctrl_hit = wr && (sel == SEL_CTRL) && loc_ok;
   assign act_loc  = loc;

   // seize outranks relinquish, relinquish outranks request (R7)
   always_comb begin
      act = ACT_NONE;
      if (ctrl_hit) begin
         if (wdata[CB_SEIZE])      act = ACT_SEIZE;
         else if (wdata[CB_REL])   act = ACT_REL;
         else if (wdata[CB_REQ])   act = ACT_REQ;
      end
   end

   // only privileged localities may raise the established flag (R10)
   assign est_set = ctrl_hit && wdata[CB_EST] && (loc >= LOC_W'(EST_MIN_LOC));

endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick
   import loc_arb_pkg::*;
#(
   parameter int NUM_LOC   = 5,
   parameter bit HIGH_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] vec,
   output logic               any,
   output logic [LOC_W-1:0]   idx
);

   assign any = |vec;

   generate
      if (HIGH_WINS) begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_LOC; i++)
               if (vec[i]) idx = LOC_W'(i);
         end
         // R3: nothing set above the chosen index
         a_r3_pick_highest: assert property (@(posedge clk) disable iff (!rst_n)
            any |-> ((vec >> idx) == NUM_LOC'(1)));
      end else begin : g_low
         logic [NUM_LOC-1:0] below_mask;
         always_comb begin
            idx = '0;
            for (int i = NUM_LOC-1; i >= 0; i--)
               if (vec[i]) idx = LOC_W'(i);
         end
         assign below_mask = (NUM_LOC'(1) << idx) - NUM_LOC'(1);
         a_r3_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            any |-> (((vec >> idx) & NUM_LOC'(1)) == NUM_LOC'(1)) && ((vec & below_mask) == '0));
      end
   endgenerate

endmodule

// File: rtl/loc_owner_core.sv
module loc_owner_core
   import loc_arb_pkg::*;
#(
   parameter int NUM_LOC   = 5,
   parameter bit HIGH_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  loc_act_e           act,
   input  logic [LOC_W-1:0]   act_loc,
   output logic               assigned_q,
   output logic [LOC_W-1:0]   owner_q,
   output logic [NUM_LOC-1:0] seized_q
);

   logic [NUM_LOC-1:0] pend_q, pend_mid, pend_nxt;
   logic [NUM_LOC-1:0] act_oh, owner_oh;
   logic [NUM_LOC-1:0] seize_set, seize_clr;
   logic               assigned_mid, assigned_nxt;
   logic [LOC_W-1:0]   owner_mid, owner_nxt;
   logic               seize_ok, writer_owns;
   logic               pick_any;
   logic [LOC_W-1:0]   pick_idx;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LOC; gi++) begin : g_oh
         assign act_oh[gi]   = (act_loc == LOC_W'(gi));
         assign owner_oh[gi] = assigned_q && (owner_q == LOC_W'(gi));
      end
   endgenerate

   assign writer_owns = |(owner_oh & act_oh);
   assign seize_ok    = (act == ACT_SEIZE) && assigned_q && (act_loc > owner_q);

   // stage 1: apply the single decoded action
   always_comb begin
      pend_mid     = pend_q;
      assigned_mid = assigned_q;
      owner_mid    = owner_q;
      seize_set    = '0;
      seize_clr    = '0;
      case (act)
         ACT_SEIZE: begin
            if (seize_ok) begin
               seize_set = owner_oh;
               owner_mid = act_loc;
               pend_mid  = pend_q & ~act_oh;
            end
         end
         ACT_REL: begin
            seize_clr = act_oh;
            if (writer_owns) assigned_mid = 1'b0;
            else             pend_mid     = pend_q & ~act_oh;
         end
         ACT_REQ: begin
            seize_clr = act_oh;
            if (!writer_owns) pend_mid = pend_q | act_oh;
         end
         default: ;
      endcase
   end

   loc_prio_pick #(
      .NUM_LOC  (NUM_LOC),
      .HIGH_WINS(HIGH_WINS)
   ) u_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .vec  (pend_mid),
      .any  (pick_any),
      .idx  (pick_idx)
   );

   // stage 2: a free module goes to the winning pending locality
   always_comb begin
      pend_nxt     = pend_mid;
      assigned_nxt = assigned_mid;
      owner_nxt    = owner_mid;
      if (!assigned_mid && pick_any) begin
         assigned_nxt = 1'b1;
         owner_nxt    = pick_idx;
         for (int i = 0; i < NUM_LOC; i++)
            if (pick_idx == LOC_W'(i)) pend_nxt[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assigned_q <= 1'b0;
         owner_q    <= '0;
         pend_q     <= '0;
      end else begin
         assigned_q <= assigned_nxt;
         owner_q    <= owner_nxt;
         pend_q     <= pend_nxt;
      end
   end

   generate
      for (gi = 0; gi < NUM_LOC; gi++) begin : g_seized
         always_ff @(posedge clk) begin
            if (!rst_n)             seized_q[gi] <= 1'b0;
            else if (seize_set[gi]) seized_q[gi] <= 1'b1;
            else if (seize_clr[gi]) seized_q[gi] <= 1'b0;
         end

         // R7: the flag rises only on the owner that a higher locality displaced
         a_r7_seized_by_higher: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(seized_q[gi]) |-> $past(assigned_q) && ($past(owner_q) == LOC_W'(gi))
                                    && assigned_q && (owner_q > LOC_W'(gi)));

         // R8: the flag holds unless its own locality requests or relinquishes
         a_r8_seized_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (seized_q[gi] && !(((act == ACT_REQ) || (act == ACT_REL)) && act_oh[gi]))
               |=> seized_q[gi]);
      end
   endgenerate

   // R9: an owner always names a real locality
   a_r9_owner_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      assigned_q |-> ({1'b0, owner_q} < (LOC_W+1)'(NUM_LOC)));

   // R3: the owner never also sits in the pending set
   a_r3_owner_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & owner_oh) == '0));

   // R4: a free module never coexists with waiting requests
   a_r4_no_idle_with_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !assigned_q |-> (pend_q == '0));

endmodule

// File: rtl/loc_est_flag.sv
module loc_est_flag #(
   parameter bit EST_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic est_set,
   input  logic hash_clr,
   output logic est_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)        est_q <= EST_RST;
      else if (hash_clr) est_q <= 1'b0;
      else if (est_set)  est_q <= 1'b1;
   end

endmodule

// File: rtl/loc_arb_top.sv
module loc_arb_top
   import loc_arb_pkg::*;
#(
   parameter int NUM_LOC     = 5,
   parameter int DATA_W      = 8,
   parameter int EST_MIN_LOC = 3,
   parameter bit HIGH_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [2:0]        reg_loc,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              hash_end,
   output logic [DATA_W-1:0] reg_rdata
);

   generate
      if (NUM_LOC < 2 || NUM_LOC > (1 << LOC_W)) begin : g_bad_num
         $error("loc_arb_top: NUM_LOC out of range for the owner field");
      end
      if (DATA_W < ST_VALID + 1) begin : g_bad_w
         $error("loc_arb_top: DATA_W too narrow for the state layout");
      end
      if (EST_MIN_LOC < 0 || EST_MIN_LOC >= NUM_LOC) begin : g_bad_est
         $error("loc_arb_top: EST_MIN_LOC must name an existing locality");
      end
   endgenerate

   loc_act_e           act;
   logic [LOC_W-1:0]   act_loc;
   logic               est_set;
   logic               assigned_q;
   logic [LOC_W-1:0]   owner_q;
   logic [NUM_LOC-1:0] seized_q;
   logic               est_q;

   loc_ctrl_decode #(
      .NUM_LOC    (NUM_LOC),
      .DATA_W     (DATA_W),
      .EST_MIN_LOC(EST_MIN_LOC)
   ) u_dec (
      .wr     (reg_wr),
      .sel    (reg_sel),
      .loc    (reg_loc),
      .wdata  (reg_wdata),
      .act    (act),
      .act_loc(act_loc),
      .est_set(est_set)
   );

   loc_owner_core #(
      .NUM_LOC  (NUM_LOC),
      .HIGH_WINS(HIGH_WINS)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .act_loc   (act_loc),
      .assigned_q(assigned_q),
      .owner_q   (owner_q),
      .seized_q  (seized_q)
   );

   loc_est_flag #(
      .EST_RST(1'b0)
   ) u_est (
      .clk     (clk),
      .rst_n   (rst_n),
      .est_set (est_set),
      .hash_clr(hash_end),
      .est_q   (est_q)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_STATE: begin
            reg_rdata[ST_VALID]              = 1'b1;
            reg_rdata[ST_LOC_LSB +: LOC_W]   = assigned_q ? owner_q : '0;
            reg_rdata[ST_ASSIGNED]           = assigned_q;
            reg_rdata[ST_EST]                = est_q;
         end
         SEL_STAT: begin
            for (int i = 0; i < NUM_LOC; i++) begin
               if (reg_loc == LOC_W'(i)) begin
                  reg_rdata[SS_GRANT]  = assigned_q && (owner_q == LOC_W'(i));
                  reg_rdata[SS_SEIZED] = seized_q[i];
               end
            end
         end
         default: ;
      endcase
   end

   // R10: the flag rises only after a privileged establishment write
   a_r10_est_privileged: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(est_q) |-> $past(reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CB_EST]
                             && (reg_loc >= 3'(EST_MIN_LOC))
                             && ({1'b0, reg_loc} < 4'(NUM_LOC))));

   // R10: the hash-end event always leaves the flag clear
   a_r10_hash_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hash_end |=> !est_q);

   // R2: the state view always carries the valid bit
   a_r2_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_STATE) |-> reg_rdata[ST_VALID]);

endmodule

// File: tb/loc_arb_top_tb_top.sv
`timescale 1ns/10ps
module loc_arb_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [2:0] reg_loc = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic       hash_end = 1'b0;
   logic [7:0] reg_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_owner;
   bit m_asg;
   bit m_est;
   bit m_pend[8];
   bit m_seiz[8];

   always #5 clk = ~clk;

   loc_arb_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_sel  (reg_sel),
      .reg_loc  (reg_loc),
      .reg_wdata(reg_wdata),
      .hash_end (hash_end),
      .reg_rdata(reg_rdata)
   );

   task automatic chk(string tag, string what, logic [7:0] act_v, logic [7:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act_v, exp_v, $time);
      end
   endtask

   function automatic logic [7:0] exp_state();
      logic [7:0] v = 8'h80;
      if (m_asg) v[4:2] = 3'(m_owner);
      v[1] = m_asg;
      v[0] = m_est;
      return v;
   endfunction

   function automatic logic [7:0] exp_status(int l);
      logic [7:0] v = 8'h00;
      v[0] = m_asg && (m_owner == l);
      v[1] = m_seiz[l];
      return v;
   endfunction

   task automatic model_reset();
      m_owner = 0; m_asg = 0; m_est = 0;
      for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_seiz[i] = 0; end
   endtask

   task automatic model_apply(bit wr, int sel, int loc, logic [7:0] d, bit hash);
      if (wr && sel == 1 && loc < 5) begin
         if (d[3] && loc >= 3) m_est = 1;
         if (d[2]) begin
            if (m_asg && loc > m_owner) begin
               m_seiz[m_owner] = 1;
               m_owner = loc;
               m_pend[loc] = 0;
            end
         end else if (d[1]) begin
            m_seiz[loc] = 0;
            if (m_asg && m_owner == loc) m_asg = 0;
            else m_pend[loc] = 0;
         end else if (d[0]) begin
            m_seiz[loc] = 0;
            if (!(m_asg && m_owner == loc)) m_pend[loc] = 1;
         end
      end
      if (hash) m_est = 0;
      if (!m_asg) begin
         for (int i = 4; i >= 0; i--) begin
            if (m_pend[i]) begin
               m_owner = i; m_asg = 1; m_pend[i] = 0;
               break;
            end
         end
      end
   endtask

   task automatic sweep(string tag);
      reg_sel = 2'd0; reg_loc = 3'd0; #0.4;
      chk(tag, "state", reg_rdata, exp_state());
      reg_sel = 2'd1; #0.4;
      chk("R2", "control read", reg_rdata, 8'h00);
      for (int i = 0; i < 5; i++) begin
         reg_sel = 2'd2; reg_loc = 3'(i); #0.4;
         chk(tag, $sformatf("status loc%0d", i), reg_rdata, exp_status(i));
      end
   endtask

   task automatic step(bit wr, int sel, int loc, logic [7:0] d, bit hash, string tag);
      @(negedge clk);
      reg_wr = wr; reg_sel = 2'(sel); reg_loc = 3'(loc); reg_wdata = d; hash_end = hash;
      @(posedge clk);
      model_apply(wr, sel, loc, d, hash);
      #0.2;
      reg_wr = 1'b0; hash_end = 1'b0;
      sweep(tag);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.2;
      sweep("R1");

      // R3: first request grants immediately
      step(1, 1, 1, 8'h01, 0, "R3");
      step(1, 1, 3, 8'h01, 0, "R3");
      step(1, 1, 2, 8'h01, 0, "R3");
      // R6: owner re-request
      step(1, 1, 1, 8'h01, 0, "R6");
      // R4: hand-off to highest pending (3)
      step(1, 1, 1, 8'h02, 0, "R4");
      // R5: relinquish by non-owners
      step(1, 1, 0, 8'h02, 0, "R5");
      step(1, 1, 0, 8'h01, 0, "R5");
      step(1, 1, 0, 8'h02, 0, "R5");
      // R4: owner 3 leaves, 2 takes over
      step(1, 1, 3, 8'h02, 0, "R4");
      // R7: higher seize, lower seize, self seize
      step(1, 1, 4, 8'h04, 0, "R7");
      step(1, 1, 0, 8'h04, 0, "R7");
      step(1, 1, 4, 8'h04, 0, "R7");
      // R9: granted bit follows owner
      step(0, 0, 0, 8'h00, 0, "R9");
      // R11: ignored writes
      step(1, 0, 4, 8'hFF, 0, "R11");
      step(1, 2, 2, 8'hFF, 0, "R11");
      step(1, 3, 1, 8'h0F, 0, "R11");
      step(1, 1, 6, 8'h0F, 0, "R11");
      // R8: flag holds, then cleared by own request
      step(1, 1, 1, 8'h01, 0, "R8");
      step(1, 1, 2, 8'h01, 0, "R8");
      // R10: establishment privilege and hash-end priority
      step(1, 1, 2, 8'h08, 0, "R10");
      step(1, 1, 3, 8'h08, 0, "R10");
      step(0, 0, 0, 8'h00, 1, "R10");
      step(1, 1, 4, 8'h08, 1, "R10");
      step(1, 1, 4, 8'h08, 0, "R10");
      // R4: drain to unassigned
      step(1, 1, 4, 8'h02, 0, "R4");
      step(1, 1, 2, 8'h02, 0, "R4");
      step(1, 1, 1, 8'h02, 0, "R4");
      // R7: seize with no owner, and strobe precedence
      step(1, 1, 3, 8'h04, 0, "R7");
      step(1, 1, 3, 8'h07, 0, "R7");
      step(1, 1, 3, 8'h01, 0, "R7");
      step(1, 1, 1, 8'h07, 0, "R7");
      step(1, 1, 1, 8'h03, 0, "R5");

      // R2: random traffic against the model
      for (int n = 0; n < 600; n++) begin
         step(1, $urandom_range(0, 3), $urandom_range(0, 7),
              8'($urandom_range(0, 15)), ($urandom_range(0, 15) == 0), "R2");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule